// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device-side serial port of a small NOR-style flash memory. A host drives a chip select, a serial clock and a data input. The block oversamples these on its own system clock through synchronisers and finds the clock edges in that domain. Input bits are taken on rising serial clock edges and output bits change on falling edges, so both idle levels of the serial clock (SPI mode 0 and mode 3) work. The block builds the opcode, address, dummy and data bytes from the input stream. It counts the serial clocks since chip select went low. When chip select rises it decides whether a write-type command counts.

An accepted command leaves the block as a one-cycle request strobe. The strobe carries a kind code, a 24-bit address and a data byte, and goes to the status and protection logic. Page program data bytes are handed out one by one as staging strobes while they arrive. The commit request only follows if the transfer ends cleanly. Array reads go through a simple fetch port: the block strobes an address and expects the byte one system clock later. Array bytes, the live status byte and the identification bytes are all sent back most significant bit first. When a read or identification command arrives during a busy internal cycle, the block gives no answer.

Top module: `spi_flash_front`

## Requirements
- R1: Input bits are captured on rising serial clock edges and output bits change on falling edges, MSB first. The same transfers work with the clock idling low (mode 0) and idling high (mode 3).
- R2: Opcode 06h issues a request with kind 1 and opcode 04h issues kind 2. Each is issued only when chip select rises after exactly 8 serial clocks.
- R3: A write-type command ends with a clock count since chip select fell that is not a multiple of eight. No request is issued for it.
- R4: Opcode 01h with one data byte and exactly 16 clocks issues kind 3, with that byte on the request data output.
- R5: Opcode 20h issues kind 5 and opcode D8h issues kind 6. Each needs exactly 32 clocks and carries the 24-bit address on the request address output.
- R6: Both C7h and 60h, sent alone in 8 clocks, issue kind 7.
- R7: After opcode 02h and a 24-bit address, each data byte gives one staging strobe. Its address keeps the upper 16 address bits, and the low byte starts at the given offset and wraps inside the 256-byte page. Kind 4, with the start address, is issued only if at least one data byte came and the count is a multiple of eight.
- R8: Opcode 03h plus a 24-bit address starts array output at that address. The address goes up by one for each byte sent, for as long as chip select stays low.
- R9: Opcode 0Bh takes one dummy byte after the address. Array output begins after that byte.
- R10: Opcode 05h returns the status input byte, sent again for every further byte. This also works while busy is high.
- R11: Opcode 9Fh returns 0Eh, 40h, 13h.
- R12: Opcode 90h plus an address returns 0Eh then 12h when address bit 0 is 0, and 12h then 0Eh when it is 1.
- R13: Opcodes 03h, 0Bh, 90h and 9Fh received while busy is high do not enable the output and issue no array fetch.
- R14: The output enable is low while chip select is high, and before the first output bit of a transfer. It returns low after chip select rises. A read that ends mid-byte issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so |
| busy_i | input | 1 | Internal program/erase/status write cycle running |
| status_i | input | 8 | Status byte to return for 05h |
| req_valid_o | output | 1 | One-cycle accepted command strobe |
| req_kind_o | output | 3 | Request kind code (see R2 to R7) |
| req_addr_o | output | 24 | Request address |
| req_data_o | output | 8 | Request data byte |
| stage_valid_o | output | 1 | Page program byte staging strobe |
| stage_addr_o | output | 24 | Staging address, wrapped within the page |
| stage_data_o | output | 8 | Staging data byte |
| mem_rd_o | output | 1 | Array fetch strobe |
| mem_addr_o | output | 24 | Array fetch address |
| mem_rdata_i | input | 8 | Array byte, valid one cycle after the fetch strobe |

## Verification
The bench ends write-type transfers one bit past a byte boundary. A front end that accepted on any count would emit erase, enable or commit requests there. Page program starts at offset FEh, so the staging addresses must wrap to 00h inside the page and must not carry into the next page. Reads cross a 256-byte line in mode 0, are repeated in mode 3, and are also cut off mid-byte. These catch a lost first bit or a wrong capture edge, a missing address increment, and output enables that stay high after chip select. Busy is raised during status reads and during read and ID commands. A design that refused status reads, or answered refused commands, would then give wrong bytes or turn on the output.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    REQ_NONE = 3'd0,
    REQ_WREN = 3'd1,
    REQ_WRDI = 3'd2,
    REQ_WRSR = 3'd3,
    REQ_PROG = 3'd4,
    REQ_SECT = 3'd5,
    REQ_BLK  = 3'd6,
    REQ_CHIP = 3'd7
  } req_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ARRAY,
    SRC_STATUS,
    SRC_JEDEC,
    SRC_MFRDEV
  } out_src_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDST  = 8'h05;
  localparam logic [7:0] OPC_WRST  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FREAD = 8'h0B;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SECT  = 8'h20;
  localparam logic [7:0] OPC_BLK   = 8'hD8;
  localparam logic [7:0] OPC_CHIPA = 8'hC7;
  localparam logic [7:0] OPC_CHIPB = 8'h60;
  localparam logic [7:0] OPC_MDID  = 8'h90;
  localparam logic [7:0] OPC_JDID  = 8'h9F;

  function automatic logic takes_addr(input logic [7:0] op);
    return (op == OPC_READ) || (op == OPC_FREAD) || (op == OPC_PROG) ||
           (op == OPC_SECT) || (op == OPC_BLK) || (op == OPC_MDID);
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             sel_end,
  input  logic             si_s,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [2:0]       bit_cnt,
  output logic [CNT_W-1:0] byte_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [6:0]       shreg_q, shreg_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [7:0]       val_q, val_d;

  always_comb begin
    shreg_d = shreg_q;
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    val_d   = val_q;
    if (sel_end) begin
      bit_d = '0;
      cnt_d = '0;
    end else if (rise) begin
      shreg_d = {shreg_q[5:0], si_s};
      bit_d   = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        done_d = 1'b1;
        val_d  = {shreg_q, si_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      val_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      val_q   <= val_d;
    end
  end

  // byte_cnt seen with byte_done is the index of the finished byte
  logic [CNT_W-1:0] idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (rise)  idx_q <= cnt_q;
  end

  assign byte_done = done_q;
  assign byte_val  = val_q;
  assign bit_cnt   = bit_q;
  assign byte_cnt  = done_q ? idx_q : cnt_q;
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       sel_end,
  input  logic       out_en,
  input  logic [7:0] load_byte,
  output logic       take,
  output logic       so,
  output logic       so_oe
);
  logic [7:0] shreg_q, shreg_d;
  logic [2:0] idx_q, idx_d;
  logic       oe_q, oe_d;
  logic       take_d, take_q;

  always_comb begin
    shreg_d = shreg_q;
    idx_d   = idx_q;
    oe_d    = oe_q;
    take_d  = 1'b0;
    if (sel_end) begin
      idx_d = '0;
      oe_d  = 1'b0;
    end else if (fall && out_en) begin
      idx_d = idx_q + 3'd1;
      oe_d  = 1'b1;
      if (idx_q == 3'd0) begin
        shreg_d = load_byte;
        take_d  = 1'b1;
      end else begin
        shreg_d = {shreg_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
      oe_q    <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      oe_q    <= oe_d;
      take_q  <= take_d;
    end
  end

  assign take  = take_q;
  assign so    = shreg_q[7];
  assign so_oe = oe_q;
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int         ADDR_W = 24,
  parameter int         CNT_W  = 3,
  parameter logic [7:0] ID_MFR = 8'h0E,
  parameter logic [7:0] ID_TYP = 8'h40,
  parameter logic [7:0] ID_CAP = 8'h13,
  parameter logic [7:0] ID_DEV = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [2:0]        bit_cnt,
  input  logic              sel_end,
  input  logic              take,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              out_en,
  output logic [7:0]        load_byte,
  output logic              req_valid_o,
  output logic [2:0]        req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_data_o,
  output logic              stage_valid_o,
  output logic [ADDR_W-1:0] stage_addr_o,
  output logic [7:0]        stage_data_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam logic [CNT_W-1:0] IDX_OP   = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX_A0   = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_ALST = CNT_W'(3);
  localparam logic [CNT_W-1:0] IDX_DUM  = CNT_W'(4);
  localparam logic [CNT_W-1:0] N_CMD    = CNT_W'(1);
  localparam logic [CNT_W-1:0] N_WRST   = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_ERASE  = CNT_W'(4);
  localparam logic [CNT_W-1:0] N_PROG   = CNT_W'(5);

  logic [7:0]        opc_q, opc_d;
  logic              refused_q, refused_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nx;
  logic [7:0]        wsr_q, wsr_d;
  logic [7:0]        pg_q, pg_d;
  logic              oen_q, oen_d;
  out_src_e          src_q, src_d;
  logic [1:0]        id_q, id_d;
  logic [ADDR_W-1:0] rda_q, rda_d;
  logic              rdp_q, rbuf_en;
  logic [7:0]        rbuf_q;
  logic              mrd_q, mrd_d;
  logic              rv_q, rv_d;
  req_kind_e         rk_q, rk_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic [7:0]        rdat_q, rdat_d;
  logic              sv_q, sv_d;
  logic [ADDR_W-1:0] sa_q, sa_d;
  logic [7:0]        sd_q, sd_d;
  logic              whole;

  assign addr_nx = {addr_q[ADDR_W-9:0], byte_val};
  assign whole   = (bit_cnt == 3'd0);
  assign rbuf_en = rdp_q;

  always_comb begin
    opc_d     = opc_q;
    refused_d = refused_q;
    addr_d    = addr_q;
    wsr_d     = wsr_q;
    pg_d      = pg_q;
    oen_d     = oen_q;
    src_d     = src_q;
    id_d      = id_q;
    rda_d     = rda_q;
    mrd_d     = 1'b0;
    rv_d      = 1'b0;
    rk_d      = rk_q;
    ra_d      = ra_q;
    rdat_d    = rdat_q;
    sv_d      = 1'b0;
    sa_d      = sa_q;
    sd_d      = sd_q;

    if (byte_done) begin
      if (byte_idx == IDX_OP) begin
        opc_d     = byte_val;
        refused_d = busy_i;
        if (byte_val == OPC_RDST) begin
          oen_d = 1'b1;
          src_d = SRC_STATUS;
        end else if (byte_val == OPC_JDID && !busy_i) begin
          oen_d = 1'b1;
          src_d = SRC_JEDEC;
          id_d  = 2'd0;
        end
      end else begin
        if (byte_idx <= IDX_ALST && takes_addr(opc_q)) addr_d = addr_nx;
        if (byte_idx == IDX_A0 && opc_q == OPC_WRST) wsr_d = byte_val;
        if (byte_idx == IDX_ALST) begin
          if (opc_q == OPC_PROG) pg_d = byte_val;
          if (opc_q == OPC_READ && !refused_q) begin
            oen_d = 1'b1;
            src_d = SRC_ARRAY;
            rda_d = addr_nx;
            mrd_d = 1'b1;
          end
          if (opc_q == OPC_MDID && !refused_q) begin
            oen_d = 1'b1;
            src_d = SRC_MFRDEV;
            id_d  = {1'b0, byte_val[0]};
          end
        end
        if (byte_idx == IDX_DUM && opc_q == OPC_FREAD && !refused_q) begin
          oen_d = 1'b1;
          src_d = SRC_ARRAY;
          rda_d = addr_q;
          mrd_d = 1'b1;
        end
        if (byte_idx >= IDX_DUM && opc_q == OPC_PROG) begin
          sv_d = 1'b1;
          sa_d = {addr_q[ADDR_W-1:8], pg_q};
          sd_d = byte_val;
          pg_d = pg_q + 8'd1;
        end
      end
    end

    if (take) begin
      case (src_q)
        SRC_ARRAY: begin
          rda_d = rda_q + 1'b1;
          mrd_d = 1'b1;
        end
        SRC_JEDEC:  id_d = (id_q == 2'd2) ? 2'd0 : id_q + 2'd1;
        SRC_MFRDEV: id_d = {1'b0, ~id_q[0]};
        default: ;
      endcase
    end

    if (sel_end) begin
      if (whole) begin
        unique case (opc_q)
          OPC_WREN: if (byte_idx == N_CMD) begin rv_d = 1'b1; rk_d = REQ_WREN; end
          OPC_WRDI: if (byte_idx == N_CMD) begin rv_d = 1'b1; rk_d = REQ_WRDI; end
          OPC_CHIPA, OPC_CHIPB:
            if (byte_idx == N_CMD) begin rv_d = 1'b1; rk_d = REQ_CHIP; end
          OPC_WRST: if (byte_idx == N_WRST) begin
            rv_d = 1'b1; rk_d = REQ_WRST_SEL(); rdat_d = wsr_q;
          end
          OPC_SECT: if (byte_idx == N_ERASE) begin
            rv_d = 1'b1; rk_d = REQ_SECT; ra_d = addr_q;
          end
          OPC_BLK: if (byte_idx == N_ERASE) begin
            rv_d = 1'b1; rk_d = REQ_BLK; ra_d = addr_q;
          end
          OPC_PROG: if (byte_idx >= N_PROG) begin
            rv_d = 1'b1; rk_d = REQ_PROG; ra_d = addr_q;
          end
          default: ;
        endcase
      end
      opc_d     = '0;
      refused_d = 1'b0;
      addr_d    = '0;
      oen_d     = 1'b0;
      src_d     = SRC_NONE;
      id_d      = '0;
      mrd_d     = 1'b0;
      sv_d      = 1'b0;
    end
  end

  function automatic req_kind_e REQ_WRST_SEL();
    return REQ_WRSR;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q     <= '0;
      refused_q <= 1'b0;
      addr_q    <= '0;
      wsr_q     <= '0;
      pg_q      <= '0;
      oen_q     <= 1'b0;
      src_q     <= SRC_NONE;
      id_q      <= '0;
      rda_q     <= '0;
      mrd_q     <= 1'b0;
      rdp_q     <= 1'b0;
      rv_q      <= 1'b0;
      rk_q      <= REQ_NONE;
      ra_q      <= '0;
      rdat_q    <= '0;
      sv_q      <= 1'b0;
      sa_q      <= '0;
      sd_q      <= '0;
    end else begin
      opc_q     <= opc_d;
      refused_q <= refused_d;
      addr_q    <= addr_d;
      wsr_q     <= wsr_d;
      pg_q      <= pg_d;
      oen_q     <= oen_d;
      src_q     <= src_d;
      id_q      <= id_d;
      rda_q     <= rda_d;
      mrd_q     <= mrd_d;
      rdp_q     <= mrd_q;
      rv_q      <= rv_d;
      rk_q      <= rk_d;
      ra_q      <= ra_d;
      rdat_q    <= rdat_d;
      sv_q      <= sv_d;
      sa_q      <= sa_d;
      sd_q      <= sd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbuf_q <= '0;
    else if (rbuf_en) rbuf_q <= mem_rdata_i;
  end

  always_comb begin
    case (src_q)
      SRC_ARRAY:  load_byte = rbuf_q;
      SRC_STATUS: load_byte = status_i;
      SRC_JEDEC:  load_byte = (id_q == 2'd0) ? ID_MFR : (id_q == 2'd1) ? ID_TYP : ID_CAP;
      SRC_MFRDEV: load_byte = id_q[0] ? ID_DEV : ID_MFR;
      default:    load_byte = 8'h00;
    endcase
  end

  assign out_en        = oen_q;
  assign req_valid_o   = rv_q;
  assign req_kind_o    = rk_q;
  assign req_addr_o    = ra_q;
  assign req_data_o    = rdat_q;
  assign stage_valid_o = sv_q;
  assign stage_addr_o  = sa_q;
  assign stage_data_o  = sd_q;
  assign mem_rd_o      = mrd_q;
  assign mem_addr_o    = rda_q;
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_fe_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_MFR      = 8'h0E,
  parameter logic [7:0] ID_TYP      = 8'h40,
  parameter logic [7:0] ID_CAP      = 8'h13,
  parameter logic [7:0] ID_DEV      = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic              req_valid_o,
  output logic [2:0]        req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_data_o,
  output logic              stage_valid_o,
  output logic [ADDR_W-1:0] stage_addr_o,
  output logic [7:0]        stage_data_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int CNT_W = 3;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // pin order in the bundle: {cs_n, sclk, si}
  logic [2:0] pins_s;
  spi_fe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({cs_n, sclk, si}), .q(pins_s)
  );

  logic cs_s, sclk_s, si_s;
  logic cs_prev_q, sclk_prev_q;
  assign {cs_s, sclk_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end

  logic rise, fall, sel_end;
  assign rise    = sclk_s & ~sclk_prev_q & ~cs_s;
  assign fall    = ~sclk_s & sclk_prev_q & ~cs_s;
  assign sel_end = cs_s & ~cs_prev_q;

  logic             byte_done;
  logic [7:0]       byte_val;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_idx;

  spi_fe_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .rise(rise), .sel_end(sel_end), .si_s(si_s),
    .byte_done(byte_done), .byte_val(byte_val), .bit_cnt(bit_cnt), .byte_cnt(byte_idx)
  );

  logic       out_en, take;
  logic [7:0] load_byte;

  spi_fe_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .ID_MFR(ID_MFR), .ID_TYP(ID_TYP), .ID_CAP(ID_CAP), .ID_DEV(ID_DEV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx), .bit_cnt(bit_cnt),
    .sel_end(sel_end), .take(take), .busy_i(busy_i), .status_i(status_i),
    .mem_rdata_i(mem_rdata_i), .out_en(out_en), .load_byte(load_byte),
    .req_valid_o(req_valid_o), .req_kind_o(req_kind_o), .req_addr_o(req_addr_o),
    .req_data_o(req_data_o), .stage_valid_o(stage_valid_o), .stage_addr_o(stage_addr_o),
    .stage_data_o(stage_data_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o)
  );

  spi_fe_tx u_tx (
    .clk(clk), .rst_n(rst_int_n), .fall(fall), .sel_end(sel_end), .out_en(out_en),
    .load_byte(load_byte), .take(take), .so(so), .so_oe(so_oe)
  );
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       req_valid_o,
  input logic [2:0] req_kind_o,
  input logic       stage_valid_o,
  input logic       mem_rd_o
);
  // R2
  req_kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_kind_o != 3'd0));

  // R3
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  // R7
  stage_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid_o |=> !stage_valid_o);

  // R8
  fetch_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  // R14
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5))
      |-> !so_oe);

  // R14
  oe_off_with_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> !so_oe);
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
  .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
  .stage_valid_o(stage_valid_o), .mem_rd_o(mem_rd_o)
);

// File: tb/spi_flash_front_bench.sv
module spi_flash_front_bench;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        so, so_oe;
  logic        busy_i = 1'b0;
  logic [7:0]  status_i = 8'h00;
  logic        req_valid_o, stage_valid_o, mem_rd_o;
  logic [2:0]  req_kind_o;
  logic [23:0] req_addr_o, stage_addr_o, mem_addr_o;
  logic [7:0]  req_data_o, stage_data_o;
  logic [7:0]  mem_rdata_i = 8'h00;

  always #4 clk = ~clk;

  spi_flash_front u_spi_flash_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .busy_i(busy_i), .status_i(status_i), .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
    .req_addr_o(req_addr_o), .req_data_o(req_data_o), .stage_valid_o(stage_valid_o),
    .stage_addr_o(stage_addr_o), .stage_data_o(stage_data_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
  );

  int tests = 0, fails = 0;
  int req_cnt = 0, stage_cnt = 0, rd_cnt = 0;
  logic [2:0]  last_kind = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic [23:0] st_addr [0:7];
  logic [7:0]  st_data [0:7];
  logic        oe_seen = 1'b0;
  logic [7:0]  txb [0:15];
  logic [7:0]  rxb [0:15];

  function automatic logic [7:0] arr(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= arr(mem_addr_o);
      rd_cnt <= rd_cnt + 1;
    end
    if (req_valid_o) begin
      req_cnt   <= req_cnt + 1;
      last_kind <= req_kind_o;
      last_addr <= req_addr_o;
      last_data <= req_data_o;
    end
    if (stage_valid_o) begin
      st_addr[stage_cnt[2:0]] <= stage_addr_o;
      st_data[stage_cnt[2:0]] <= stage_data_o;
      stage_cnt <= stage_cnt + 1;
    end
    if (so_oe) oe_seen <= 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_tx();
    for (int i = 0; i < 16; i++) begin txb[i] = 8'h00; rxb[i] = 8'h00; end
    oe_seen = 1'b0;
  endtask

  task automatic spi_run(input int nbits, input bit m3);
    sclk = m3; waitc(H);
    cs_n = 1'b0; waitc(H);
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      si = txb[b/8][7 - (b%8)];
      waitc(H);
      rxb[b/8][7 - (b%8)] = so;
      sclk = 1'b1;
      waitc(H);
    end
    if (!m3) sclk = 1'b0;
    waitc(H);
    cs_n = 1'b1;
    waitc(2*H);
  endtask

  task automatic t_reset();
    chk(so_oe == 1'b0, "R14 oe at reset", so_oe, 0);
    chk(req_cnt == 0 && stage_cnt == 0 && rd_cnt == 0, "R14 quiet at reset", req_cnt + stage_cnt + rd_cnt, 0);
  endtask

  task automatic t_enables();
    int n0;
    clear_tx(); txb[0] = 8'h06; n0 = req_cnt; spi_run(8, 0);
    chk(req_cnt == n0 + 1 && last_kind == 3'd1, "R2 write enable kind", last_kind, 1);
    clear_tx(); txb[0] = 8'h04; n0 = req_cnt; spi_run(8, 1);
    chk(req_cnt == n0 + 1 && last_kind == 3'd2, "R2 write disable kind (mode 3)", last_kind, 2);
    clear_tx(); txb[0] = 8'h06; n0 = req_cnt; spi_run(9, 0);
    chk(req_cnt == n0, "R3 enable with 9 clocks dropped", req_cnt - n0, 0);
  endtask

  task automatic t_wrsr();
    int n0;
    clear_tx(); txb[0] = 8'h01; txb[1] = 8'h9C; n0 = req_cnt; spi_run(16, 0);
    chk(req_cnt == n0 + 1 && last_kind == 3'd3, "R4 status write kind", last_kind, 3);
    chk(last_data == 8'h9C, "R4 status write data", last_data, 8'h9C);
  endtask

  task automatic t_erase();
    int n0;
    clear_tx(); txb[0] = 8'h20; txb[1] = 8'h00; txb[2] = 8'h3A; txb[3] = 8'h55;
    n0 = req_cnt; spi_run(32, 0);
    chk(req_cnt == n0 + 1 && last_kind == 3'd5, "R5 sector erase kind", last_kind, 5);
    chk(last_addr == 24'h003A55, "R5 sector erase addr", last_addr, 24'h003A55);
    clear_tx(); txb[0] = 8'hD8; txb[1] = 8'h01; txb[2] = 8'h80; txb[3] = 8'h07;
    n0 = req_cnt; spi_run(32, 1);
    chk(req_cnt == n0 + 1 && last_kind == 3'd6 && last_addr == 24'h018007, "R5 block erase", last_addr, 24'h018007);
    clear_tx(); txb[0] = 8'h20; n0 = req_cnt; spi_run(33, 0);
    chk(req_cnt == n0, "R3 erase with 33 clocks dropped", req_cnt - n0, 0);
    clear_tx(); txb[0] = 8'hC7; n0 = req_cnt; spi_run(8, 0);
    chk(req_cnt == n0 + 1 && last_kind == 3'd7, "R6 chip erase C7", last_kind, 7);
    clear_tx(); txb[0] = 8'h60; n0 = req_cnt; spi_run(8, 1);
    chk(req_cnt == n0 + 1 && last_kind == 3'd7, "R6 chip erase 60", last_kind, 7);
  endtask

  task automatic t_program();
    int n0, s0;
    clear_tx(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h12; txb[3] = 8'hFE;
    txb[4] = 8'hAA; txb[5] = 8'hBB; txb[6] = 8'hCC;
    n0 = req_cnt; s0 = stage_cnt; spi_run(56, 0);
    chk(stage_cnt == s0 + 3, "R7 staging count", stage_cnt - s0, 3);
    chk(st_addr[s0[2:0]] == 24'h0012FE && st_data[s0[2:0]] == 8'hAA, "R7 stage 0", st_addr[s0[2:0]], 24'h0012FE);
    chk(st_addr[(s0+2)%8] == 24'h001200 && st_data[(s0+2)%8] == 8'hCC, "R7 stage wrap", st_addr[(s0+2)%8], 24'h001200);
    chk(req_cnt == n0 + 1 && last_kind == 3'd4 && last_addr == 24'h0012FE, "R7 commit", last_addr, 24'h0012FE);
    n0 = req_cnt; spi_run(57, 0);
    chk(req_cnt == n0, "R7 ragged program dropped", req_cnt - n0, 0);
    clear_tx(); txb[0] = 8'h02; n0 = req_cnt; spi_run(32, 0);
    chk(req_cnt == n0, "R7 program without data dropped", req_cnt - n0, 0);
  endtask

  task automatic t_read();
    int n0;
    clear_tx(); txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h01; txb[3] = 8'hFE;
    spi_run(56, 0);
    chk(rxb[4] == arr(24'h0001FE), "R8 read byte 0", rxb[4], arr(24'h0001FE));
    chk(rxb[5] == arr(24'h0001FF) && rxb[6] == arr(24'h000200), "R8 read increments", rxb[6], arr(24'h000200));
    chk(so_oe == 1'b0, "R14 oe low after read", so_oe, 0);
    clear_tx(); txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'hAB; txb[3] = 8'hCD;
    spi_run(48, 1);
    chk(rxb[4] == arr(24'h00ABCD) && rxb[5] == arr(24'h00ABCE), "R1 read in mode 3", rxb[5], arr(24'h00ABCE));
    clear_tx(); txb[0] = 8'h03; n0 = req_cnt; spi_run(37, 0);
    chk(req_cnt == n0 && so_oe == 1'b0, "R14 read cut mid-byte", req_cnt - n0, 0);
    clear_tx(); txb[0] = 8'h0B; txb[3] = 8'h10; txb[4] = 8'hFF;
    spi_run(56, 0);
    chk(rxb[5] == arr(24'h000010) && rxb[6] == arr(24'h000011), "R9 fast read after dummy", rxb[5], arr(24'h000010));
  endtask

  task automatic t_status_id();
    int r0;
    busy_i = 1'b1; status_i = 8'hA5;
    clear_tx(); txb[0] = 8'h05; spi_run(24, 0);
    chk(rxb[1] == 8'hA5 && rxb[2] == 8'hA5, "R10 status repeats while busy", rxb[2], 8'hA5);
    clear_tx(); txb[0] = 8'h03; r0 = rd_cnt; spi_run(48, 0);
    chk(!oe_seen && rd_cnt == r0, "R13 read refused when busy", rd_cnt - r0, 0);
    clear_tx(); txb[0] = 8'h9F; spi_run(24, 1);
    chk(!oe_seen, "R13 jedec id refused when busy", oe_seen, 0);
    busy_i = 1'b0;
    clear_tx(); txb[0] = 8'h9F; spi_run(32, 0);
    chk(rxb[1] == 8'h0E && rxb[2] == 8'h40 && rxb[3] == 8'h13, "R11 jedec id", {rxb[1], rxb[2], rxb[3]}, 24'h0E4013);
    clear_tx(); txb[0] = 8'h90; spi_run(48, 0);
    chk(rxb[4] == 8'h0E && rxb[5] == 8'h12, "R12 ids maker first", {rxb[4], rxb[5]}, 16'h0E12);
    clear_tx(); txb[0] = 8'h90; txb[3] = 8'h01; spi_run(48, 1);
    chk(rxb[4] == 8'h12 && rxb[5] == 8'h0E, "R12 ids device first", {rxb[4], rxb[5]}, 16'h120E);
  endtask

  initial begin
    fork
      begin
        waitc(5); rst_n = 1'b1; waitc(10);
        t_reset();
        t_enables();
        t_wrsr();
        t_erase();
        t_program();
        t_read();
        t_status_id();
      end
      begin
        waitc(150000);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule